// File: doc/BRIEF.md
# Accumulator Processor Sequencing Controller

This block is the control unit of a small accumulator processor with four instructions: load, store, add and branch-when-negative. It holds a 4-bit Moore state register and steps through instruction fetch, a single decode state, and a short execute sequence for each instruction. Every output is a pure function of the registered state, so the strobes stay glitch-free.

It emits one strobe per register transfer and three memory controls (request, read, write). The datapath, the memory and the ALU sit outside the block. They take the strobes and return a memory wait handshake, the two opcode bits of the instruction register and the accumulator sign bit.

The restart request and the memory wait input each pass through a register stage before the state logic sees them. This adds one cycle of latency to both. The opcode and sign inputs are already registered in the datapath and are used directly.

Top module: `acc_ctrl`

## Requirements
- R1: An active-low asynchronous `rst_ni` puts the state at RES. A high `restart_i` sampled on one edge forces RES on the following edge, from any state. RES always moves to IF0 when no restart is pending.
- R2: `state_o` shows the state code: RES=0, IF0=1, IF1=2, IF2=3, IF3=4, OD=5, LD0=6, LD1=7, LD2=8, ST0=9, ST1=10, AD0=11, AD1=12, AD2=13, BR0=14, BR1=15.
- R3: IF0 always moves to IF1.
- R4: The state logic sees `wait_i` as sampled one edge earlier. IF1 holds while that value is low and advances to IF2 when it is high. IF2 holds while it is high and advances to IF3 when it is low. IF3 holds while it is low and advances to OD when it is high.
- R5: OD moves on `op_i` as follows: 00 to LD0, 01 to ST0, 10 to AD0, 11 to BR0.
- R6: Load runs LD0, then LD1, then LD2, then IF0. Add runs AD0, then AD1, then AD2, then IF0. LD1 and AD1 hold while the delayed wait is high.
- R7: Store runs ST0, then ST1, then IF0. ST1 holds while the delayed wait is high.
- R8: BR0 goes to IF0 when `sign_i`=0 and to BR1 when `sign_i`=1. BR1 always goes to IF0.
- R9: Each bit of `xfer_o` is high exactly in the states listed here:
  - bit0 clears PC: RES
  - bit1 increments PC: IF0
  - bit2 copies PC to MAR: IF0
  - bit3 captures memory data into MBR: IF2, LD1, AD1
  - bit4 copies MBR to IR: IF3
  - bit5 copies the IR address to MAR: LD0, ST0, AD0
  - bit6 copies AC to MBR: ST0
  - bit7 drives MBR onto the data bus: ST1
  - bit8 copies MBR to AC: LD2
  - bit9 writes AC+MBR into AC: AD2
  - bit10 copies the IR address to PC: BR1
- R10: `mem_req_o` is high in IF2, LD1, AD1 and ST1. `mem_rd_o` is high in IF2, LD1 and AD1. `mem_wr_o` is high only in ST1. Read and write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart request, registered before use |
| wait_i | input | 1 | Memory wait handshake, registered before use |
| op_i | input | 2 | Opcode bits from the instruction register |
| sign_i | input | 1 | Accumulator sign bit |
| state_o | output | 4 | Current state code |
| xfer_o | output | 11 | Register-transfer strobes |
| mem_req_o | output | 1 | Memory request |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |

## Verification
Fetch is run with several different lengths for each of the three wait phases, including the shortest possible one. This separates a correct level-sensitive hold from an off-by-one in the single-cycle wait delay. Every opcode is then decoded after its own fetch, and each branch is run with both sign values, so a swapped decode entry or an inverted condition shows up as a wrong state code. A restart is issued in the middle of a wait phase to expose its one-cycle latency. In every cycle, the full strobe and memory-control vectors are compared with the state-to-output map, so a strobe moved to another state is caught.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    S_RES = 4'd0,  S_IF0 = 4'd1,  S_IF1 = 4'd2,  S_IF2 = 4'd3,
    S_IF3 = 4'd4,  S_OD  = 4'd5,  S_LD0 = 4'd6,  S_LD1 = 4'd7,
    S_LD2 = 4'd8,  S_ST0 = 4'd9,  S_ST1 = 4'd10, S_AD0 = 4'd11,
    S_AD1 = 4'd12, S_AD2 = 4'd13, S_BR0 = 4'd14, S_BR1 = 4'd15
  } state_e;

  // strobe positions in xfer_o
  localparam int X_PC_CLR    = 0;
  localparam int X_PC_INC    = 1;
  localparam int X_PC_MAR    = 2;
  localparam int X_MEM_MBR   = 3;
  localparam int X_MBR_IR    = 4;
  localparam int X_IRA_MAR   = 5;
  localparam int X_AC_MBR    = 6;
  localparam int X_MBR_BUS   = 7;
  localparam int X_MBR_AC    = 8;
  localparam int X_ADD_AC    = 9;
  localparam int X_IRA_PC    = 10;
  localparam int XFER_W      = 11;

  typedef struct packed {
    logic req;
    logic rd;
    logic wr;
  } mem_ctl_t;
endpackage

// File: rtl/acc_ctrl_sync.sv
module acc_ctrl_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/acc_ctrl_next.sv
module acc_ctrl_next
  import acc_ctrl_pkg::*;
(
  input  state_e          state_i,
  input  logic            restart_i,
  input  logic            wait_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            sign_i,
  output state_e          state_next_o
);
  state_e nxt;

  always_comb begin
    nxt = state_i;
    unique case (state_i)
      S_RES: nxt = S_IF0;
      S_IF0: nxt = S_IF1;
      S_IF1: nxt = wait_i ? S_IF2 : S_IF1;
      S_IF2: nxt = wait_i ? S_IF2 : S_IF3;
      S_IF3: nxt = wait_i ? S_OD  : S_IF3;
      S_OD: begin
        unique case (op_i)
          2'b00: nxt = S_LD0;
          2'b01: nxt = S_ST0;
          2'b10: nxt = S_AD0;
          default: nxt = S_BR0;
        endcase
      end
      S_LD0: nxt = S_LD1;
      S_LD1: nxt = wait_i ? S_LD1 : S_LD2;
      S_LD2: nxt = S_IF0;
      S_ST0: nxt = S_ST1;
      S_ST1: nxt = wait_i ? S_ST1 : S_IF0;
      S_AD0: nxt = S_AD1;
      S_AD1: nxt = wait_i ? S_AD1 : S_AD2;
      S_AD2: nxt = S_IF0;
      S_BR0: nxt = sign_i ? S_BR1 : S_IF0;
      S_BR1: nxt = S_IF0;
      default: nxt = S_RES;
    endcase
    if (restart_i) nxt = S_RES;
  end

  assign state_next_o = nxt;
endmodule

// File: rtl/acc_ctrl_decode.sv
module acc_ctrl_decode
  import acc_ctrl_pkg::*;
(
  input  state_e            state_i,
  output logic [XFER_W-1:0] xfer_o,
  output mem_ctl_t          mem_o
);
  always_comb begin
    xfer_o = '0;
    mem_o  = '0;
    unique case (state_i)
      S_RES: xfer_o[X_PC_CLR] = 1'b1;
      S_IF0: begin
        xfer_o[X_PC_INC] = 1'b1;
        xfer_o[X_PC_MAR] = 1'b1;
      end
      S_IF2, S_LD1, S_AD1: begin
        xfer_o[X_MEM_MBR] = 1'b1;
        mem_o.req = 1'b1;
        mem_o.rd  = 1'b1;
      end
      S_IF3: xfer_o[X_MBR_IR] = 1'b1;
      S_LD0, S_AD0: xfer_o[X_IRA_MAR] = 1'b1;
      S_ST0: begin
        xfer_o[X_IRA_MAR] = 1'b1;
        xfer_o[X_AC_MBR]  = 1'b1;
      end
      S_ST1: begin
        xfer_o[X_MBR_BUS] = 1'b1;
        mem_o.req = 1'b1;
        mem_o.wr  = 1'b1;
      end
      S_LD2: xfer_o[X_MBR_AC] = 1'b1;
      S_AD2: xfer_o[X_ADD_AC] = 1'b1;
      S_BR1: xfer_o[X_IRA_PC] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                wait_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic                sign_i,
  output logic [STATE_W-1:0]  state_o,
  output logic [XFER_W-1:0]   xfer_o,
  output logic                mem_req_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o
);
  logic     restart_q, wait_q;
  state_e   state_q, state_d;
  mem_ctl_t mem_ctl;

  acc_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_restart (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(restart_i), .q_o(restart_q)
  );

  acc_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wait_i), .q_o(wait_q)
  );

  acc_ctrl_next u_next (
    .state_i(state_q), .restart_i(restart_q), .wait_i(wait_q),
    .op_i(op_i), .sign_i(sign_i), .state_next_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_RES;
    else         state_q <= state_d;
  end

  acc_ctrl_decode u_dec (
    .state_i(state_q), .xfer_o(xfer_o), .mem_o(mem_ctl)
  );

  assign state_o   = state_q;
  assign mem_req_o = mem_ctl.req;
  assign mem_rd_o  = mem_ctl.rd;
  assign mem_wr_o  = mem_ctl.wr;
endmodule

// File: rtl/acc_ctrl_chk.sv
module acc_ctrl_chk
  import acc_ctrl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                restart_i,
  input logic [OP_W-1:0]     op_i,
  input logic [STATE_W-1:0]  state_o,
  input logic                mem_req_o,
  input logic                mem_rd_o,
  input logic                mem_wr_o
);
  AST_RESTART_TO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ##1 (state_o == S_RES)); // R1

  AST_IF0_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_IF0 && !$past(restart_i)) |=> (state_o == S_IF1)); // R3

  AST_DECODE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_OD && !$past(restart_i)) |=>
      (state_o == S_LD0 || state_o == S_ST0 || state_o == S_AD0 || state_o == S_BR0)); // R5

  AST_BR1_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_BR1) |-> ($past(state_o) == S_BR0)); // R8

  AST_NO_RW_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R10

  AST_ACCESS_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> mem_req_o); // R10
endmodule

bind acc_ctrl acc_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .op_i(op_i),
  .state_o(state_o), .mem_req_o(mem_req_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o)
);

// File: tb/acc_ctrl_test.sv
`timescale 1ns/1ps
module acc_ctrl_test;
  import acc_ctrl_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        wt = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        sign = 1'b0;
  logic [3:0]  state;
  logic [10:0] xfer;
  logic        req, rd, wr;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  acc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .wait_i(wt),
    .op_i(op), .sign_i(sign), .state_o(state), .xfer_o(xfer),
    .mem_req_o(req), .mem_rd_o(rd), .mem_wr_o(wr)
  );

  // R9 map, written from the requirement
  function automatic logic [10:0] exp_xfer(input logic [3:0] s);
    logic [10:0] x = '0;
    case (s)
      4'd0:  x[0] = 1'b1;
      4'd1:  begin x[1] = 1'b1; x[2] = 1'b1; end
      4'd3, 4'd7, 4'd12: x[3] = 1'b1;
      4'd4:  x[4] = 1'b1;
      4'd6, 4'd11: x[5] = 1'b1;
      4'd9:  begin x[5] = 1'b1; x[6] = 1'b1; end
      4'd10: x[7] = 1'b1;
      4'd8:  x[8] = 1'b1;
      4'd13: x[9] = 1'b1;
      4'd15: x[10] = 1'b1;
      default: ;
    endcase
    return x;
  endfunction

  // R10 map: {req, rd, wr}
  function automatic logic [2:0] exp_mem(input logic [3:0] s);
    case (s)
      4'd3, 4'd7, 4'd12: return 3'b110;
      4'd10:             return 3'b101;
      default:           return 3'b000;
    endcase
  endfunction

  task automatic check_all(input logic [3:0] exp, input string tag);
    total++;
    if (state !== exp) begin
      bad++;
      $display("FAIL %s state act=%0d exp=%0d", tag, state, exp);
    end
    total++;
    if (xfer !== exp_xfer(exp)) begin
      bad++;
      $display("FAIL R9 strobes in %s act=%b exp=%b", tag, xfer, exp_xfer(exp));
    end
    total++;
    if ({req, rd, wr} !== exp_mem(exp)) begin
      bad++;
      $display("FAIL R10 memctl in %s act=%b exp=%b", tag, {req, rd, wr}, exp_mem(exp));
    end
  endtask

  // drive wait at negedge, step one edge, check at next negedge
  task automatic tick(input logic w, input logic [3:0] exp, input string tag);
    wt = w;
    @(posedge clk);
    @(negedge clk);
    check_all(exp, tag);
  endtask

  // starts in IF0 with wait low last applied; ends in OD, wait high last applied
  task automatic do_fetch(input int n1, input int n2, input int n3);
    tick(1'b0, S_IF1, "R3 IF0->IF1");
    for (int i = 0; i < n1; i++) tick(1'b0, S_IF1, "R4 IF1 hold");
    tick(1'b1, S_IF1, "R4 IF1 wait delay");
    tick(1'b1, S_IF2, "R4 IF2 enter");
    for (int i = 0; i < n2; i++) tick(1'b1, S_IF2, "R4 IF2 hold");
    tick(1'b0, S_IF2, "R4 IF2 wait delay");
    tick(1'b0, S_IF3, "R4 IF3 enter");
    for (int i = 0; i < n3; i++) tick(1'b0, S_IF3, "R4 IF3 hold");
    tick(1'b1, S_IF3, "R4 IF3 wait delay");
    tick(1'b1, S_OD, "R4 OD enter");
  endtask

  task automatic test_load(input int n1, input int n2, input int n3, input int m);
    op = 2'b00;
    do_fetch(n1, n2, n3);
    tick(1'b1, S_LD0, "R5 op00");
    tick(1'b1, S_LD1, "R6 LD1");
    for (int i = 0; i < m; i++) tick(1'b1, S_LD1, "R6 LD1 hold");
    tick(1'b0, S_LD1, "R6 LD1 delay");
    tick(1'b0, S_LD2, "R6 LD2");
    tick(1'b0, S_IF0, "R6 load done");
  endtask

  task automatic test_add(input int n1, input int n2, input int n3, input int m);
    op = 2'b10;
    do_fetch(n1, n2, n3);
    tick(1'b1, S_AD0, "R5 op10");
    tick(1'b1, S_AD1, "R6 AD1");
    for (int i = 0; i < m; i++) tick(1'b1, S_AD1, "R6 AD1 hold");
    tick(1'b0, S_AD1, "R6 AD1 delay");
    tick(1'b0, S_AD2, "R6 AD2");
    tick(1'b0, S_IF0, "R6 add done");
  endtask

  task automatic test_store(input int n1, input int n2, input int n3, input int m);
    op = 2'b01;
    do_fetch(n1, n2, n3);
    tick(1'b1, S_ST0, "R5 op01");
    tick(1'b1, S_ST1, "R7 ST1");
    for (int i = 0; i < m; i++) tick(1'b1, S_ST1, "R7 ST1 hold");
    tick(1'b0, S_ST1, "R7 ST1 delay");
    tick(1'b0, S_IF0, "R7 store done");
  endtask

  task automatic test_branch(input logic neg);
    op = 2'b11;
    sign = ~neg;   // sign away from BR0 must not matter
    do_fetch(0, 1, 0);
    sign = neg;
    tick(1'b0, S_BR0, "R5 op11");
    if (neg) begin
      tick(1'b0, S_BR1, "R8 taken");
      tick(1'b0, S_IF0, "R8 BR1 done");
    end else begin
      tick(1'b0, S_IF0, "R8 not taken");
    end
  endtask

  task automatic test_restart();
    tick(1'b0, S_IF1, "R3 IF0->IF1");
    tick(1'b1, S_IF1, "R4 IF1 wait delay");
    tick(1'b1, S_IF2, "R4 IF2 enter");
    restart = 1'b1;
    tick(1'b1, S_IF2, "R1 restart latency");
    tick(1'b1, S_RES, "R1 restart forces RES");
    restart = 1'b0;
    tick(1'b0, S_RES, "R1 RES held by restart");
    tick(1'b0, S_IF0, "R1 RES->IF0");
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_all(S_RES, "R1 R2 in reset");
    rst_n = 1'b1;
    tick(1'b0, S_IF0, "R1 RES->IF0");
    test_load(1, 2, 1, 2);
    test_add(0, 0, 0, 0);
    test_store(3, 1, 2, 1);
    test_branch(1'b0);
    test_branch(1'b1);
    test_load(0, 0, 0, 4);
    test_restart();
    test_store(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule